// File: doc/BRIEF.md
# GPIO Pad Bank with Shared Interrupt Lines

This block is a register-mapped controller for a small bank of general-purpose pads. Each pad owns two 32-bit control words. The first word sets the pad's direction, its output value, whether it runs as a GPIO, its pull direction, and which interrupt line it reports to. The second word sets the trigger condition and an optional inversion of the received value. Each pad input passes through a two-flop synchronizer and is then optionally inverted. The result is captured into a readable receive bit and fed to a per-pad falling, rising, both-edge or level detector.

Detector events are routed through a 4-bit per-pad selector onto sixteen shared lines. These lines set bits in a status register that software clears by writing ones. A mask register gates the status bits into one registered interrupt output. The host reaches all of this through a plain 32-bit read/write port. Read data returns one cycle after the request, together with a valid strobe.

Top module: `padbank_ctrl`

## Requirements
- R1: After reset, the status register (offset 0x300) and the mask register (offset 0x380) read 0, and every pad control word reads 0. Only bits 15:0 of status and mask exist, and their bits 31:16 read 0.
- R2: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a detector event and a clear hit the same status bit in the same cycle, the bit stays set.
- R3: The interrupt output is the OR of (status AND mask) over the 16 lines, registered one cycle after status. A masked line never raises it.
- R4: Pad p's first control word is at 0x4400 + (p/15)*0x400 + (p%15)*8, and its second word is 4 bytes above. Offsets that decode to no register read 0 and ignore writes: misaligned offsets, slot 15 of a chunk, pads at or beyond the pad count, and offsets such as 0x304.
- R5: First control word layout: bit 0 is the receive state, read-only; bit 1 is the output value; bits 10:8 are the direction; bit 15 is the GPIO enable; bit 23 selects pull-up (1) or pull-down (0); bits 31:28 are the interrupt line. All other bits read 0.
- R6: Direction 0 enables output and input, 1 enables output only, 2 enables input only, and 3 disables both. pad_oe is high only when GPIO is enabled and the direction enables output. pad_out carries bit 1, and pad_pull carries bit 23.
- R7: The receive state takes the synchronized, possibly inverted input only while the direction enables input, and holds its value otherwise. It reflects a pad change two clock edges after the edge that first samples it.
- R8: Second control word bits 2:0 select the trigger: 0 off, 1 falling edge, 2 rising edge, 3 both edges, 4 level. An edge event sets the pad's line status bit on the third clock edge after the pad change, once per edge.
- R9: In level mode the status bit is set on every cycle in which the (possibly inverted) input is high, so a clear does not hold while the input stays active.
- R10: Second control word bit 6 inverts the received value ahead of both the receive state and the detector.
- R11: Each pad sets only the status bit selected by its bits 31:28, and two pads routed to different lines set different bits.
- R12: A pad whose GPIO enable is 0, or whose direction disables input, never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (16) | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | rdata holds the answer to the previous cycle's read |
| pad_in | input | NUM_PADS (30) | Raw pad inputs |
| pad_out | output | NUM_PADS (30) | Output value per pad |
| pad_oe | output | NUM_PADS (30) | Output enable per pad |
| pad_pull | output | NUM_PADS (30) | 1 = pull-up, 0 = pull-down |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
Suppose a pad input changes just before clock edge A. The synchronized value is present after edge A+1. The receive bit and the status bit update at edge A+2, and irq_out follows at edge A+3.

Register reads answer on the edge that samples rd_en. Control-word writes take effect on the sampling edge, so pad_oe and pad_out can be read at the next falling edge.

The bench changes pads on a falling edge and waits four full cycles before reading status or sampling irq_out, which puts every sample after its due edge. Read results are queued at issue and compared when rd_valid rises. An edge is tested by a read that shows the status bit set, then a clear, then a read that shows the bit gone. A level is tested by a read that shows the bit still set after the clear.

// File: rtl/padbank_pkg.sv
package padbank_pkg;
  localparam int LINES       = 16;
  localparam int LINE_W      = 4;
  localparam int CHUNK_PADS  = 15;
  localparam int CHUNK_SHIFT = 10;
  localparam logic [15:0] STATUS_OFS = 16'h0300;
  localparam logic [15:0] MASK_OFS   = 16'h0380;
  localparam logic [15:0] PAD_BASE   = 16'h4400;

  typedef enum logic [2:0] {
    TRIG_OFF   = 3'd0,
    TRIG_FALL  = 3'd1,
    TRIG_RISE  = 3'd2,
    TRIG_BOTH  = 3'd3,
    TRIG_LEVEL = 3'd4
  } trig_e;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic              pull;
    logic              en;
    logic [2:0]        dir;
    logic              tx;
  } ctl0_t;

  typedef struct packed {
    logic  inv;
    trig_e trig;
  } ctl1_t;
endpackage

// File: rtl/pbk_addr_decode.sv
module pbk_addr_decode
  import padbank_pkg::*;
#(
  parameter int NUM_PADS = 30,
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_status,
  output logic              hit_mask,
  output logic              hit_pad,
  output logic [IDX_W-1:0]  pad_idx,
  output logic              word_sel
);
  logic [ADDR_W-1:0] rel;
  int unsigned chunk_n, slot_n, pad_n;

  always_comb begin
    rel        = addr - ADDR_W'(PAD_BASE);
    chunk_n    = 32'(rel >> CHUNK_SHIFT);
    slot_n     = 32'(rel[CHUNK_SHIFT-1:3]);
    pad_n      = chunk_n * CHUNK_PADS + slot_n;
    hit_status = (addr == ADDR_W'(STATUS_OFS));
    hit_mask   = (addr == ADDR_W'(MASK_OFS));
    hit_pad    = (addr >= ADDR_W'(PAD_BASE)) && (rel[1:0] == 2'b00) &&
                 (slot_n < CHUNK_PADS) && (pad_n < NUM_PADS);
    pad_idx    = IDX_W'(pad_n);
    word_sel   = rel[2];
  end
endmodule

// File: rtl/pbk_pad_slice.sv
module pbk_pad_slice
  import padbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we0,
  input  logic              we1,
  input  logic [31:0]       wdata,
  input  logic              pad_in,
  output logic [31:0]       word0,
  output logic [31:0]       word1,
  output logic              evt,
  output logic [LINE_W-1:0] line,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_pull
);
  ctl0_t c0;
  ctl1_t c1;
  logic  s1, s2, prev_v, rx_q;
  logic  v, rx_en, tx_en, armed;
  logic  unused_wbits;

  assign unused_wbits = ^{wdata[0], wdata[5:3], wdata[7], wdata[14:11],
                          wdata[22:16], wdata[27:24]};

  assign v     = s2 ^ c1.inv;
  assign rx_en = (c0.dir == 3'd0) || (c0.dir == 3'd2);
  assign tx_en = (c0.dir == 3'd0) || (c0.dir == 3'd1);
  assign armed = c0.en && rx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      prev_v <= 1'b0;
      rx_q   <= 1'b0;
      c0     <= '0;
      c1     <= '{inv: 1'b0, trig: TRIG_OFF};
    end else begin
      s1     <= pad_in;
      s2     <= s1;
      prev_v <= v;
      if (rx_en) rx_q <= v;
      if (we0) begin
        c0.line <= wdata[31:28];
        c0.pull <= wdata[23];
        c0.en   <= wdata[15];
        c0.dir  <= wdata[10:8];
        c0.tx   <= wdata[1];
      end
      if (we1) begin
        c1.inv  <= wdata[6];
        c1.trig <= trig_e'(wdata[2:0]);
      end
    end
  end

  always_comb begin
    evt = 1'b0;
    if (armed) begin
      case (c1.trig)
        TRIG_FALL:  evt = prev_v && !v;
        TRIG_RISE:  evt = !prev_v && v;
        TRIG_BOTH:  evt = prev_v ^ v;
        TRIG_LEVEL: evt = v;
        default:    evt = 1'b0;
      endcase
    end
  end

  assign word0    = {c0.line, 4'b0, c0.pull, 7'b0, c0.en, 4'b0, c0.dir, 6'b0, c0.tx, rx_q};
  assign word1    = {25'b0, c1.inv, 3'b0, c1.trig};
  assign line     = c0.line;
  assign pad_out  = c0.tx;
  assign pad_oe   = c0.en && tx_en;
  assign pad_pull = c0.pull;

  // R8: a rising-edge event lasts a single cycle while the configuration is untouched
  p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
    (evt && c1.trig == TRIG_RISE && !we0 && !we1) |=> !evt);

  // R7: receive state holds while input is disabled
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!rx_en) |=> $stable(rx_q));
endmodule

// File: rtl/pbk_irq_merge.sv
module pbk_irq_merge
  import padbank_pkg::*;
#(
  parameter int NUM_PADS = 30
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PADS-1:0]        evt,
  input  logic [NUM_PADS*LINE_W-1:0] line_sel,
  input  logic                       st_we,
  input  logic                       mk_we,
  input  logic [LINES-1:0]           wbits,
  output logic [LINES-1:0]           status,
  output logic [LINES-1:0]           mask,
  output logic                       irq
);
  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] clr_vec;

  always_comb begin
    set_vec = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (evt[p]) set_vec[line_sel[p*LINE_W +: LINE_W]] = 1'b1;
    end
  end

  assign clr_vec = st_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      if (mk_we) mask <= wbits;
      irq    <= |(status & mask);
    end
  end

  // R2: set beats a simultaneous clear
  p_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R2: a clear with no competing event removes the bits
  p_w1c_r2: assert property (@(posedge clk) disable iff (rst)
    (st_we && ((wbits & set_vec) == '0)) |=> ((status & $past(wbits)) == '0));

  // R3: the output only rises from an unmasked line
  p_irq_masked_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(mask) != '0));

  // R3: clearing every mask bit silences the output one cycle later
  p_mask_off_r3: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);
endmodule

// File: rtl/padbank_ctrl.sv
module padbank_ctrl
  import padbank_pkg::*;
#(
  parameter int NUM_PADS = 30,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                rd_valid,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_pull,
  output logic                irq_out
);
  localparam int IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  logic                       hit_status, hit_mask, hit_pad, word_sel;
  logic [IDX_W-1:0]           pad_idx;
  logic [31:0]                word0 [NUM_PADS];
  logic [31:0]                word1 [NUM_PADS];
  logic [NUM_PADS-1:0]        evt;
  logic [NUM_PADS*LINE_W-1:0] line_sel;
  logic [LINES-1:0]           status, mask;
  logic [31:0]                rd_next;

  pbk_addr_decode #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .hit_status(hit_status), .hit_mask(hit_mask),
    .hit_pad(hit_pad), .pad_idx(pad_idx), .word_sel(word_sel)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    logic sel_me;
    assign sel_me = wr_en && hit_pad && (pad_idx == IDX_W'(i));
    pbk_pad_slice u_slice (
      .clk(clk), .rst(rst),
      .we0(sel_me && !word_sel), .we1(sel_me && word_sel),
      .wdata(wdata), .pad_in(pad_in[i]),
      .word0(word0[i]), .word1(word1[i]), .evt(evt[i]),
      .line(line_sel[i*LINE_W +: LINE_W]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i]), .pad_pull(pad_pull[i])
    );
  end

  pbk_irq_merge #(.NUM_PADS(NUM_PADS)) u_irq (
    .clk(clk), .rst(rst), .evt(evt), .line_sel(line_sel),
    .st_we(wr_en && hit_status), .mk_we(wr_en && hit_mask),
    .wbits(wdata[LINES-1:0]), .status(status), .mask(mask), .irq(irq_out)
  );

  always_comb begin
    rd_next = '0;
    if (hit_status)   rd_next = 32'(status);
    else if (hit_mask) rd_next = 32'(mask);
    else if (hit_pad)  rd_next = word_sel ? word1[pad_idx] : word0[pad_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? rd_next : '0;
    end
  end

  // R4: unmapped reads return zero
  p_unmapped_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit_status && !hit_mask && !hit_pad) |=> (rdata == '0));

  // R4: at most one register target per offset
  p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_status, hit_mask, hit_pad}));
endmodule

// File: tb/padbank_ctrl_bench.sv
module padbank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rd_valid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pull;
  logic irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  padbank_ctrl u_padbank_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull), .irq_out(irq_out)
  );

  function automatic logic [15:0] pad_addr(input int p, input int w);
    return 16'(32'h4400 + (p / 15) * 32'h400 + (p % 15) * 8 + w * 4);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  task automatic set_pad(input int p, input logic v);
    @(negedge clk);
    pad_in[p] = v;
    wait_cyc(4);
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rd_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: got %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: read got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [31:0] C0_3  = 32'h5000_8200; // line 5, enabled, input only
  localparam logic [31:0] C0_20 = 32'h9000_8000; // line 9, enabled, both directions

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);

    // R1 reset state
    do_read(16'h0300, 32'h0, "R1 status");
    do_read(16'h0380, 32'h0, "R1 mask");
    do_read(16'h4418, 32'h0, "R1 pad3 word0");
    do_read(16'h441C, 32'h0, "R1 pad3 word1");
    check("R1 irq", 32'(irq_out), 32'h0);
    check("R1 oe", 32'(pad_oe), 32'h0);

    // R5 rx bit is read-only; R4 address arithmetic
    check("R4 addr pad3", 32'(pad_addr(3, 0)), 32'h4418);
    do_write(16'h4418, C0_3 | 32'h1);
    do_write(16'h441C, 32'h2);
    do_write(16'h0380, 32'h20);
    do_read(16'h4418, C0_3, "R5 rx read-only");
    do_read(16'h441C, 32'h2, "R8 trig readback");

    // R8 rising edge, R3 irq, R7 rx state
    set_pad(3, 1'b1);
    check("R3 irq on", 32'(irq_out), 32'h1);
    do_read(16'h0300, 32'h20, "R8 rise sets");
    do_read(16'h4418, C0_3 | 32'h1, "R7 rx follows");
    do_write(16'h0300, 32'h20);
    wait_cyc(2);
    do_read(16'h0300, 32'h0, "R2 w1c");
    check("R3 irq off", 32'(irq_out), 32'h0);
    set_pad(3, 1'b0);
    do_read(16'h0300, 32'h0, "R8 rise ignores fall");

    // R8 falling
    do_write(16'h441C, 32'h1);
    set_pad(3, 1'b1);
    do_read(16'h0300, 32'h0, "R8 fall ignores rise");
    set_pad(3, 1'b0);
    do_read(16'h0300, 32'h20, "R8 fall sets");
    do_write(16'h0300, 32'h20);

    // R8 both edges
    do_write(16'h441C, 32'h3);
    set_pad(3, 1'b1);
    do_read(16'h0300, 32'h20, "R8 both rise");
    do_write(16'h0300, 32'h20);
    set_pad(3, 1'b0);
    do_read(16'h0300, 32'h20, "R8 both fall");
    do_write(16'h0300, 32'h20);
    do_read(16'h0300, 32'h0, "R2 both cleared");

    // R10 inversion with rising trigger (inversion change makes one edge)
    do_write(16'h441C, 32'h42);
    wait_cyc(4);
    do_write(16'h0300, 32'h20);
    do_read(16'h441C, 32'h42, "R10 word1");
    do_read(16'h4418, C0_3 | 32'h1, "R10 rx inverted");
    set_pad(3, 1'b1);
    do_read(16'h0300, 32'h0, "R10 inv rise on pad fall only");
    set_pad(3, 1'b0);
    do_read(16'h0300, 32'h20, "R10 inv rise");
    do_write(16'h0300, 32'h20);

    // R9 level
    do_write(16'h441C, 32'h4);
    wait_cyc(4);
    do_write(16'h0300, 32'h20);
    do_read(16'h0300, 32'h0, "R9 level idle");
    set_pad(3, 1'b1);
    do_read(16'h0300, 32'h20, "R9 level high");
    do_write(16'h0300, 32'h20);
    wait_cyc(2);
    do_read(16'h0300, 32'h20, "R9 level persists R2 set wins");
    set_pad(3, 1'b0);
    do_write(16'h0300, 32'h20);
    do_read(16'h0300, 32'h0, "R9 level released");
    do_write(16'h441C, 32'h44);
    wait_cyc(4);
    do_read(16'h0300, 32'h20, "R10 inverted level active on low");
    set_pad(3, 1'b1);
    do_write(16'h0300, 32'h20);
    wait_cyc(2);
    do_read(16'h0300, 32'h0, "R10 inverted level idle on high");

    // R11 routing, pad 20 in second chunk
    do_write(16'h441C, 32'h2);
    set_pad(3, 1'b0);
    do_write(16'h0300, 32'hFFFF);
    check("R4 addr pad20", 32'(pad_addr(20, 0)), 32'h4828);
    do_write(16'h4828, C0_20);
    do_write(16'h482C, 32'h2);
    do_write(16'h0380, 32'h220);
    do_read(16'h0300, 32'h0, "R11 idle");
    set_pad(20, 1'b1);
    do_read(16'h0300, 32'h200, "R11 pad20 line9");
    do_read(16'h4828, C0_20 | 32'h1, "R4 pad20 word0");
    check("R6 pad20 oe", 32'(pad_oe[20]), 32'h1);
    set_pad(3, 1'b1);
    do_read(16'h0300, 32'h220, "R11 both lines");
    do_write(16'h0300, 32'h220);
    do_read(16'h0300, 32'h0, "R2 clear two");

    // R3 masking
    set_pad(3, 1'b0);
    set_pad(20, 1'b0);
    do_write(16'h0380, 32'h200);
    set_pad(3, 1'b1);
    check("R3 masked", 32'(irq_out), 32'h0);
    do_read(16'h0300, 32'h20, "R3 status while masked");
    do_write(16'h0380, 32'h220);
    wait_cyc(2);
    check("R3 unmasked", 32'(irq_out), 32'h1);
    do_write(16'h0300, 32'h20);

    // R12 gating, R7 hold
    do_write(16'h4418, 32'h5000_8300);
    set_pad(3, 1'b0);
    do_read(16'h4418, 32'h5000_8301, "R7 rx held when input off");
    set_pad(3, 1'b1);
    do_read(16'h0300, 32'h0, "R12 input disabled");
    do_write(16'h4418, 32'h5000_0200);
    set_pad(3, 1'b0);
    set_pad(3, 1'b1);
    do_read(16'h0300, 32'h0, "R12 gpio disabled");
    do_read(16'h4418, 32'h5000_0201, "R7 rx with gpio off");

    // R6 direction
    do_write(16'h4418, 32'h0080_8102);
    check("R6 oe out-only", 32'(pad_oe[3]), 32'h1);
    check("R6 out", 32'(pad_out[3]), 32'h1);
    check("R6 pull", 32'(pad_pull[3]), 32'h1);
    do_read(16'h4418, 32'h0080_8103, "R5 word0 fields");
    do_write(16'h4418, 32'h0000_8202);
    check("R6 oe input-only", 32'(pad_oe[3]), 32'h0);
    do_write(16'h4418, 32'h0000_0002);
    check("R6 oe gpio off", 32'(pad_oe[3]), 32'h0);

    // R4 unmapped, R1 high bits
    do_write(16'h4478, 32'hFFFF_FFFF);
    do_read(16'h4478, 32'h0, "R4 slot15");
    do_read(16'h4C00, 32'h0, "R4 pad30");
    do_write(16'h0304, 32'hFFFF);
    do_read(16'h0304, 32'h0, "R4 0x304");
    do_read(16'h0300, 32'h0, "R4 status untouched");
    do_read(16'h4419, 32'h0, "R4 misaligned");
    do_write(pad_addr(29, 0), 32'h3000_0000);
    do_read(16'h4870, 32'h3000_0000, "R4 pad29");
    do_write(16'h0380, 32'hFFFF_FFFF);
    do_read(16'h0380, 32'h0000_FFFF, "R1 mask width");

    wait_cyc(4);
    check("queue drained", 32'(exp_q.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule